// File: doc/BRIEF.md
# Three-wire serial EEPROM command engine

This block turns a bit-serial EEPROM-style protocol into single parallel operations on a 16-bit backing bus. It watches a serial clock and a serial data line. The serial clock must already be synchronized to the system clock. A 16-bit shift register takes one data bit on every rising serial edge. A small position counter marks the frame boundaries, so the register itself is never cleared. Each completed frame becomes an address set, a data write or a data read on the parallel side.

The block does not own the shared bus mode. It reads the current mode on `mode_in`. It proposes a new mode on `mode_next` and marks that proposal with a one-cycle `mode_set`; the surrounding bus logic commits it. Any mode with bits 3:2 not equal to 00 is foreign to this engine. The first serial edge seen in such a mode opens a 9-bit command frame. When the command ends, the engine picks the data phase directly from two opcode bits.

The parallel bus has no back-pressure. Every strobe lasts one system cycle and must be taken in that cycle. For a read, the returned word is sampled during the read strobe cycle. The word is then shifted out most significant bit first on `ser_dout`.

Top module: `tw_eeprom_engine`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `mode_set`, `addr_stb`, `wr_stb` and `rd_stb` are low and `ser_dout` is 0.
- R2: A rising serial edge seen while `mode_in[3:2]` is not 00 makes `mode_set` pulse with `mode_next` = 0011 (command mode). It issues no bus strobe, and that edge counts as the first bit of a 9-bit command frame.
- R3: On every rising serial edge the 16-bit register shifts left by one bit and takes `ser_din` into bit 0. It is never cleared between frames. `ser_dout` always shows register bit 15.
- R4: The 9th edge of a command frame (mode 0011) completes it. `mode_next` = 00 followed by opcode bits 7:6, counting bit 8 as the first bit received. Read 110000000 gives 0010, write 101000000 gives 0001, and erase/write disable 100000000 and erase/write enable 100110000 both give 0000.
- R5: Command completion pulses `addr_stb`. `addr_out` is 0x3F in bits 15:8, the last received command bit in bit 7, and 0 in bits 6:0.
- R6: In mode 0001 the 16th serial edge after the command pulses `wr_stb`. `wr_data` then equals the last 16 bits received, with the first one received in bit 15. `mode_next` = 0000 with `mode_set`.
- R7: In mode 0010 the 16th serial edge after the command pulses `rd_stb`, with `mode_next` = 0000 and `mode_set`. `bus_rdata` is sampled during the `rd_stb` cycle and loaded into the register. Later edges shift that word out on `ser_dout`, most significant bit first.
- R8: `mode_set` and each strobe are high for exactly one system cycle. They rise in the cycle that follows the first system clock edge that samples `ser_clk` high. At most one bus strobe is high at a time, and each one comes with `mode_set`.
- R9: Serial edges in idle mode 0000 only shift the register. They raise no strobe and no `mode_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, already synchronized to `clk` |
| ser_din | input | 1 | Serial data in |
| mode_in | input | 4 | Current shared bus mode |
| bus_rdata | input | 16 | Word returned by the backing bus, sampled while `rd_stb` is high |
| mode_next | output | 4 | Proposed next bus mode |
| mode_set | output | 1 | One-cycle pulse: commit `mode_next` |
| addr_stb | output | 1 | One-cycle address-set strobe |
| addr_out | output | 16 | Forced parallel address |
| wr_stb | output | 1 | One-cycle data-write strobe |
| wr_data | output | 16 | Parallel write data (register contents) |
| rd_stb | output | 1 | One-cycle data-read strobe |
| ser_dout | output | 1 | Serial data out, register bit 15 |

## Verification
A wrong position count moves the completion strobe to a different serial edge, so the error shows at the ports within one serial bit time. A wrongly cleared or badly shifted register shows on `ser_dout` right after the next serial edge, and again in `wr_data` at the end of a write. A wrong mode proposal shows in the `mode_next` value that comes with the next `mode_set`. Because the mode is fed back through `mode_in`, one bad proposal also puts every later strobe on the wrong edge. The bench therefore compares the strobes, the mode proposal, the address, the write data and the serial output against a reference model on every system cycle.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_IDLE  = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_WRITE = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_READ  = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_CMD   = 4'b0011;
  localparam logic [7:0]        ADDR_HI    = 8'h3F;
endpackage

// File: rtl/tw_edge_det.sv
module tw_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end
  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  assign q_next = {q[W-2:0], din};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= q_next;
  end
endmodule

// File: rtl/tw_pos_cnt.sv
module tw_pos_cnt #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          step,
  output logic          at_zero
);
  logic [PW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt - 1'b1;
  end
  assign at_zero = (cnt == '0);
endmodule

// File: rtl/tw_eeprom_engine.sv
module tw_eeprom_engine #(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic [3:0]        mode_in,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [3:0]        mode_next,
  output logic              mode_set,
  output logic              addr_stb,
  output logic [DATA_W-1:0] addr_out,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_stb,
  output logic              ser_dout
);
  import tw_pkg::*;

  localparam int PW     = $clog2(DATA_W);
  localparam int SEL_HI = CMD_W - 2;
  localparam int LOW_W  = DATA_W - 9;
  localparam logic [PW-1:0] CMD_LOAD  = PW'(CMD_W - 2);
  localparam logic [PW-1:0] DATA_LOAD = PW'(DATA_W - 1);

  logic              rise;
  logic              at_zero;
  logic              foreign;
  logic              busy;
  logic              pos_load;
  logic              pos_step;
  logic [PW-1:0]     pos_val;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;

  tw_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ser_clk), .rise(rise)
  );

  tw_shifter #(.W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .shift_en(rise), .din(ser_din),
    .load_en(rd_stb), .load_val(bus_rdata), .q(sh_q), .q_next(sh_next)
  );

  assign foreign  = (mode_in[3:2] != 2'b00);
  assign busy     = !foreign && (mode_in != MODE_IDLE);
  assign pos_load = rise && (foreign || (busy && at_zero));
  assign pos_step = rise && busy && !at_zero;
  assign pos_val  = foreign ? CMD_LOAD : DATA_LOAD;

  tw_pos_cnt #(.PW(PW)) u_pos (
    .clk(clk), .rst_n(rst_n), .load(pos_load), .load_val(pos_val),
    .step(pos_step), .at_zero(at_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_next <= MODE_IDLE;
      mode_set  <= 1'b0;
      addr_stb  <= 1'b0;
      wr_stb    <= 1'b0;
      rd_stb    <= 1'b0;
      addr_out  <= '0;
    end else begin
      mode_set <= 1'b0;
      addr_stb <= 1'b0;
      wr_stb   <= 1'b0;
      rd_stb   <= 1'b0;
      if (rise) begin
        if (foreign) begin
          mode_next <= MODE_CMD;
          mode_set  <= 1'b1;
        end else if (busy && at_zero) begin
          mode_set <= 1'b1;
          if (mode_in == MODE_CMD) begin
            mode_next <= {2'b00, sh_next[SEL_HI:SEL_HI-1]};
            addr_stb  <= 1'b1;
            addr_out  <= {ADDR_HI, sh_next[0], {LOW_W{1'b0}}};
          end else begin
            mode_next <= MODE_IDLE;
            wr_stb    <= (mode_in == MODE_WRITE);
            rd_stb    <= (mode_in == MODE_READ);
          end
        end
      end
    end
  end

  assign wr_data  = sh_q;
  assign ser_dout = sh_q[DATA_W-1];
endmodule

// File: rtl/tw_eeprom_engine_chk.sv
module tw_eeprom_engine_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [3:0]        mode_next,
  input logic              mode_set,
  input logic              addr_stb,
  input logic [DATA_W-1:0] addr_out,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic              ser_dout
);
  // R8: one bus strobe at a time, each accompanied by mode_set, each one cycle
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_stb, wr_stb, rd_stb}));
  assert_strobe_has_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb || wr_stb || rd_stb) |-> mode_set);
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_set || addr_stb || wr_stb || rd_stb) |=> !(mode_set || addr_stb || wr_stb || rd_stb));
  // R4: proposed modes always belong to this engine
  assert_mode_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_set && !(mode_next == 4'b0011)) |-> (mode_next[3:2] == 2'b00));
  // R5: forced address pattern
  assert_addr_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |-> (addr_out[DATA_W-1:DATA_W-8] == 8'h3F && addr_out[DATA_W-10:0] == '0));
  // R6: write returns to idle
  assert_wr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (mode_next == 4'b0000));
  // R7: read returns to idle and the sampled word shows its top bit next
  assert_rd_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (mode_next == 4'b0000));
  assert_rd_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (ser_dout == $past(bus_rdata[DATA_W-1])));
endmodule

bind tw_eeprom_engine tw_eeprom_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata), .mode_next(mode_next),
  .mode_set(mode_set), .addr_stb(addr_stb), .addr_out(addr_out),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .ser_dout(ser_dout)
);

// File: tb/tb_tw_eeprom_engine.sv
`timescale 1ns/1ps
module tb_tw_eeprom_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic [3:0]  mode_reg = 4'b0100;
  logic [15:0] bus_rdata = 16'h9E17;
  logic [3:0]  mode_next;
  logic        mode_set, addr_stb, wr_stb, rd_stb, ser_dout;
  logic [15:0] addr_out, wr_data;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tw_eeprom_engine dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .mode_in(mode_reg), .bus_rdata(bus_rdata), .mode_next(mode_next),
    .mode_set(mode_set), .addr_stb(addr_stb), .addr_out(addr_out),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .ser_dout(ser_dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced on each rising clock
  bit          m_prev_ser;
  bit [15:0]   m_word;
  int          m_pos;
  bit          e_mset, e_addr, e_wr, e_rd;
  bit [3:0]    e_mnext;
  bit [15:0]   e_aout;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev_ser = 0; m_word = 0; m_pos = 0;
      e_mset = 0; e_addr = 0; e_wr = 0; e_rd = 0; e_mnext = 0; e_aout = 0;
    end else begin
      bit rise_m, load_m;
      rise_m = ser_clk && !m_prev_ser;
      m_prev_ser = ser_clk;
      load_m = e_rd;
      e_mset = 0; e_addr = 0; e_wr = 0; e_rd = 0;
      if (load_m) m_word = bus_rdata;
      else if (rise_m) m_word = {m_word[14:0], ser_din};
      if (rise_m) begin
        if (mode_reg[3:2] != 2'b00) begin
          m_pos = 7; e_mnext = 4'b0011; e_mset = 1;
        end else if (mode_reg != 4'b0000) begin
          if (m_pos == 0) begin
            m_pos = 15; e_mset = 1;
            if (mode_reg == 4'b0011) begin
              e_mnext = {2'b00, m_word[7:6]};
              e_addr = 1;
              e_aout = 16'h3F00 | (16'(m_word[0]) << 7);
            end else begin
              e_mnext = 4'b0000;
              e_wr = (mode_reg == 4'b0001);
              e_rd = (mode_reg == 4'b0010);
            end
          end else m_pos--;
        end
      end
    end
  end

  int cnt_addr = 0, cnt_wr = 0, cnt_rd = 0, cnt_mset = 0;
  bit [15:0] last_addr, last_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(mode_set == e_mset, "R8 mode_set timing", mode_set, e_mset);
      chk(addr_stb == e_addr, "R5 addr_stb timing", addr_stb, e_addr);
      chk(wr_stb == e_wr, "R6 wr_stb timing", wr_stb, e_wr);
      chk(rd_stb == e_rd, "R7 rd_stb timing", rd_stb, e_rd);
      chk(ser_dout == m_word[15], "R3 ser_dout", ser_dout, m_word[15]);
      if (e_mset) chk(mode_next == e_mnext, "R4 mode_next", mode_next, e_mnext);
      if (e_addr) chk(addr_out == e_aout, "R5 addr_out", addr_out, e_aout);
      if (e_wr) chk(wr_data == m_word, "R6 wr_data", wr_data, m_word);
      if (addr_stb) begin cnt_addr++; last_addr = addr_out; end
      if (wr_stb) begin cnt_wr++; last_wdata = wr_data; end
      if (rd_stb) cnt_rd++;
      if (mode_set) begin cnt_mset++; mode_reg = mode_next; end
    end
  end

  task automatic send_bit(input bit b);
    ser_din = b; ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input bit [8:0] op);
    int a0;
    mode_reg = 4'b1000;
    @(negedge clk);
    a0 = cnt_addr;
    send_bit(op[8]);
    chk(mode_reg == 4'b0011, "R2 enter command mode", mode_reg, 3);
    chk(cnt_addr == a0, "R2 no strobe on start", cnt_addr, a0);
    for (int i = 7; i >= 0; i--) send_bit(op[i]);
    chk(cnt_addr == a0 + 1, "R8 one address strobe", cnt_addr, a0 + 1);
  endtask

  task automatic send_word(input bit [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({mode_set, addr_stb, wr_stb, rd_stb, ser_dout} == 5'b0, "R1 reset outputs",
        {mode_set, addr_stb, wr_stb, rd_stb, ser_dout}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mode_set, addr_stb, wr_stb, rd_stb, ser_dout} == 5'b0, "R1 after release",
        {mode_set, addr_stb, wr_stb, rd_stb, ser_dout}, 0);

    // write with address bit set
    send_frame(9'b101000001);
    chk(mode_reg == 4'b0001, "R4 write opcode mode", mode_reg, 1);
    chk(last_addr == 16'h3F80, "R5 address bit one", last_addr, 16'h3F80);
    send_word(16'hA5C3);
    chk(cnt_wr == 1, "R6 one write", cnt_wr, 1);
    chk(last_wdata == 16'hA5C3, "R6 write data", last_wdata, 16'hA5C3);
    chk(mode_reg == 4'b0000, "R6 back to idle", mode_reg, 0);

    // read
    send_frame(9'b110000000);
    chk(mode_reg == 4'b0010, "R4 read opcode mode", mode_reg, 2);
    chk(last_addr == 16'h3F00, "R5 address bit zero", last_addr, 16'h3F00);
    send_word(16'h0000);
    chk(cnt_rd == 1, "R7 one read", cnt_rd, 1);
    chk(mode_reg == 4'b0000, "R7 back to idle", mode_reg, 0);
    begin
      bit [15:0] got;
      int ms;
      ms = cnt_mset;
      for (int i = 15; i >= 0; i--) begin
        got[i] = ser_dout;
        send_bit(1'b0);
      end
      chk(got == 16'h9E17, "R7 serial read-out", got, 16'h9E17);
      chk(cnt_mset == ms, "R9 idle edges no mode change", cnt_mset, ms);
      chk(cnt_wr + cnt_rd == 2, "R9 idle edges no strobes", cnt_wr + cnt_rd, 2);
    end

    // idle shifting keeps earlier bits (never cleared)
    send_word(16'hC000);
    chk(ser_dout == 1'b1, "R3 register holds shifted bits", ser_dout, 1);

    // enable and disable opcodes fall back to idle
    send_frame(9'b100110000);
    chk(mode_reg == 4'b0000, "R4 enable opcode idle", mode_reg, 0);
    send_frame(9'b100000000);
    chk(mode_reg == 4'b0000, "R4 disable opcode idle", mode_reg, 0);
    chk(cnt_addr == 4, "R5 address strobes", cnt_addr, 4);

    // second write, different pattern
    send_frame(9'b101000000);
    send_word(16'h5A3C);
    chk(last_wdata == 16'h5A3C, "R6 second write data", last_wdata, 16'h5A3C);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule